// File: doc/BRIEF.md
# Handshaked two-tap averaging filter

The block is a streaming filter with one input channel and one output channel. Both channels use four-phase request/acknowledge signalling. For each value `x` that arrives, the block emits the floor of `(x + y) / 2`. Here `y` is the value accepted in the previous transaction, and `y` is zero before the first transaction.

The computation is not driven by a state counter. A chain of request/acknowledge links passes control through an input capture stage, then a two-part previous-sample stage, then an adder whose completion follows a matched delay, and finally an output hold stage. Each stage closes once it has acknowledged its request. The previous-sample stage captures `x` while its request is high. The value it shows to the adder changes only when that request falls. By then the result is already held in the output stage.

The environment may change the input data as soon as the input acknowledge rises. The sample that was captured is not disturbed by this.

Top module: `avg2_hs_filter`

## Requirements
- R1: After reset, `out_req_o` and `in_ack_o` are 0, and the stored previous sample is 0, so the first output equals floor(x/2).
- R2: Each output word equals floor((x + y) / 2). The sum is formed with one extra carry bit, so for 8-bit data, 255 and 255 give 255 and 255 and 0 give 127.
- R3: After each transaction the previous sample becomes that transaction's `x`. It changes only after `in_req_i` has been withdrawn.
- R4: `out_data_o` is held constant for every cycle in which `out_req_o` stays high.
- R5: `in_ack_o` follows `out_ack_i`, so the input is acknowledged only once the output consumer has acknowledged.
- R6: While `in_req_i` stays high after `in_ack_o` has risen, `out_req_o` stays high and no new result is issued. `out_req_o` falls only after `in_req_i` has fallen.
- R7: The adder reports completion `ADD_DELAY` cycles after its request. `out_req_o` is first seen high `ADD_DELAY + 3` clock edges after the edge that first samples `in_req_i` high.
- R8: Input data that changes after `in_ack_o` rises affects neither the current output nor the stored previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_req_i | input | 1 | Input request; the data is valid while this is high |
| in_data_i | input | W | Input sample x, unsigned |
| in_ack_o | output | 1 | Input acknowledge |
| out_req_o | output | 1 | Output request; the result is valid while this is high |
| out_data_o | output | W | Averaged result |
| out_ack_i | input | 1 | Output acknowledge from the consumer |

## Verification
The assertions assume that both neighbours follow the four-phase rules. A request stays high until its acknowledge rises and stays low until its acknowledge falls, and `out_ack_i` rises only in answer to `out_req_o`. The bench acts as both neighbours in that way. It waits on each acknowledge before it changes the matching request. It never holds back an acknowledge, and it only disturbs `in_data_i` in the window the protocol allows. The sweep passes through every 8-bit input value in a scrambled order and adds extreme pairs, so both the carry bit and the rounding toward zero are exercised.

// File: rtl/avg2_pkg.sv
package avg2_pkg;
  typedef struct packed {
    logic req;
    logic ack;
  } link_t;
endpackage

// File: rtl/hs_hold_stage.sv
module hs_hold_stage #(
  parameter int W      = 8,
  parameter bit TWO_PT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  output logic         ack_o,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         ack_q;
  logic [W-1:0] mst_q;

  // open from request until acknowledged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      mst_q <= '0;
    end else begin
      ack_q <= req_i;
      if (req_i && !ack_q) mst_q <= d_i;
    end
  end

  assign ack_o = ack_q;

  generate
    if (TWO_PT) begin : g_two
      logic [W-1:0] slv_q;
      // visible copy moves on release of the request
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               slv_q <= '0;
        else if (!req_i && ack_q)  slv_q <= mst_q;
      end
      assign q_o = slv_q;
    end else begin : g_one
      assign q_o = mst_q;
    end
  endgenerate

  p_req_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_o) |=> req_i);
  p_closed_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> $stable(mst_q));
endmodule

// File: rtl/hs_avg_adder.sv
module hs_avg_adder #(
  parameter int W         = 8,
  parameter int ADD_DELAY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  output logic         ack_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] avg_o
);
  localparam int SW = W + 1;
  localparam int CW = $clog2(ADD_DELAY + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(ADD_DELAY - 1);

  logic          ack_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sum_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign avg_o = sum_w[SW-1:1];

  // matched delay: count while requested and not yet done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else if (!req_i) begin
      ack_q <= 1'b0;
      cnt_q <= '0;
    end else if (!ack_q) begin
      if (cnt_q == LAST) ack_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ack_o = ack_q;

  p_done_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> req_i);
  p_done_waited_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_i));
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (avg_o >= (a_i >> 1)) && (avg_o >= (b_i >> 1)));
endmodule

// File: rtl/avg2_hs_filter.sv
module avg2_hs_filter
  import avg2_pkg::*;
#(
  parameter int W         = 8,
  parameter int ADD_DELAY = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_req_i,
  input  logic [W-1:0] in_data_i,
  output logic         in_ack_o,
  output logic         out_req_o,
  output logic [W-1:0] out_data_o,
  input  logic         out_ack_i
);
  link_t        lx, ly, la, lo;
  logic [W-1:0] x_q, y_q, avg_w;

  // request chain: each stage is requested by the previous acknowledge
  assign lx.req = in_req_i;
  assign ly.req = lx.ack;
  assign la.req = ly.ack;
  assign lo.req = la.ack;
  assign out_req_o = lo.ack;
  assign in_ack_o  = out_ack_i;

  hs_hold_stage #(.W(W), .TWO_PT(1'b0)) i_x (
    .clk_i, .rst_ni, .req_i(lx.req), .ack_o(lx.ack), .d_i(in_data_i), .q_o(x_q));

  hs_hold_stage #(.W(W), .TWO_PT(1'b1)) i_y (
    .clk_i, .rst_ni, .req_i(ly.req), .ack_o(ly.ack), .d_i(x_q), .q_o(y_q));

  hs_avg_adder #(.W(W), .ADD_DELAY(ADD_DELAY)) i_add (
    .clk_i, .rst_ni, .req_i(la.req), .ack_o(la.ack),
    .a_i(x_q), .b_i(y_q), .avg_o(avg_w));

  hs_hold_stage #(.W(W), .TWO_PT(1'b0)) i_o (
    .clk_i, .rst_ni, .req_i(lo.req), .ack_o(lo.ack), .d_i(avg_w), .q_o(out_data_o));

  p_out_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_req_o && $past(out_req_o)) |-> $stable(out_data_o));
  p_y_after_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_q) |-> !in_req_i);
  p_in_ack_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> out_req_o);
  p_out_rise_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_req_o) |-> in_req_i);
  p_out_fall_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_req_o) |-> !in_req_i);
endmodule

// File: tb/test_avg2_hs_filter.sv
module test_avg2_hs_filter;
  localparam int W  = 8;
  localparam int AD = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_req = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack, out_req, out_ack = 1'b0;
  logic [W-1:0] out_data;
  int checks = 0, fails = 0, cyc = 0;
  logic [W-1:0] y_exp = '0;

  always #10 clk = ~clk;

  avg2_hs_filter #(.W(W), .ADD_DELAY(AD)) i_avg2_hs_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_req_i(in_req), .in_data_i(in_data),
    .in_ack_o(in_ack), .out_req_o(out_req), .out_data_o(out_data), .out_ack_i(out_ack));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic transact(input logic [W-1:0] x, input bit disturb);
    int n = 0;
    int exp = (int'(x) + int'(y_exp)) / 2;
    in_data = x;
    in_req  = 1'b1;
    do begin @(negedge clk); n++; end while (!out_req);
    check("R7 latency", n, AD + 3);
    check("R2 average", int'(out_data), exp);
    @(negedge clk);
    check("R4 hold", int'(out_data), exp);
    check("R5 no early ack", int'(in_ack), 0);
    out_ack = 1'b1;
    #1 check("R5 ack follows", int'(in_ack), 1);
    if (disturb) begin
      in_data = ~x;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R6 held", int'(out_req), 1);
        check("R8 output intact", int'(out_data), exp);
      end
    end
    @(negedge clk);
    in_req = 1'b0;
    while (out_req) @(negedge clk);
    out_ack = 1'b0;
    #1 check("R5 ack release", int'(in_ack), 0);
    @(negedge clk);
    y_exp = x;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_req reset", int'(out_req), 0);
    check("R1 in_ack reset", int'(in_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_req idle", int'(out_req), 0);
    transact(8'd201, 1'b0);             // R1: y=0 gives 100
    transact(8'd255, 1'b0);             // R2
    transact(8'd255, 1'b1);             // R2 carry: 255, R8
    transact(8'd0, 1'b0);               // R2: 127
    transact(8'd1, 1'b1);               // R3 rounding down
    for (int i = 0; i < 256; i++)       // every value, scrambled order
      transact(W'((i * 37 + 11) % 256), (i % 5) == 0);
    for (int i = 0; i < 16; i++)        // extreme alternation, R2 and R3
      transact((i % 2) ? 8'd255 : 8'd0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule